// File: doc/BRIEF.md
# Frame Arrival Prediction Synchronizer

This block lives in a slave node on a ring bus. Each frame that passes its integrity check gives a one-clock strobe. These strobes pick up jitter as the frame travels from node to node, so the block does not use them as its timing reference. It runs its own prediction counter with a period that starts at the nominal communication cycle, which the master supplies as a count of clocks. Each real frame moves the arrival time of the next prediction at most one correction step later or earlier. The steady predicted-arrival pulse that results starts a delay timer, and that timer produces the node's sync pulse.

The first accepted frame fixes the time origin. After that the predicted pulses keep coming whether or not frames arrive. A gap counter detects frames that never come. A missing frame is flagged and treated as though it had arrived on time: the prediction goes back to the nominal period and the node keeps running on its own count. After a loss, the gap limit drops from the enlarged worst-case interval to the plain nominal interval, until a real frame arrives again.

Top module: `frame_arrival_sync`

## Requirements
- R1: After reset, and until the first `frame_ok` strobe, `pred_arrive`, `sync_out` and `frame_lost` stay low. Frame loss is not checked before the first frame.
- R2: The first `frame_ok` sampled at clock edge E0 raises `pred_arrive` for one clock after edge E0. While no correction applies, the pulse repeats after edges E0 + k·`cycle_len`.
- R3: A `frame_ok` sampled at the same edge that produces a predicted pulse counts as a difference of zero. The period stays at `cycle_len`.
- R4: A frame sampled d edges after a predicted pulse, where DIFF_TH < d ≤ period/2, sets the period to `cycle_len` + CORR_STEP. This period applies to the interval already running. (Defaults: DIFF_TH = 2, CORR_STEP = 1.)
- R5: A frame sampled d edges before the next predicted pulse, where d > DIFF_TH, sets the period to `cycle_len` − CORR_STEP. This also applies to the interval already running.
- R6: A frame whose distance from the nearest predicted pulse is at most DIFF_TH sets the period back to exactly `cycle_len`.
- R7: If no frame is sampled for `cycle_len` + MAX_FLUCT + 1 edges after the last frame (default MAX_FLUCT = 8), `frame_lost` goes high for one clock. The period returns to `cycle_len`, and the predicted pulses continue.
- R8: After a loss, the next loss is flagged `cycle_len` + 1 edges later if no frame comes. A real frame restores the limit of R7. A frame sampled at the same edge as a would-be loss prevents that loss.
- R9: `sync_out` goes high for one clock after edge P + 2 + `sync_offset`, where P is the edge that raised `pred_arrive`. A new predicted pulse reloads the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_ok | input | 1 | One-clock strobe for a frame that passed its check |
| cycle_len | input | CNT_W | Nominal communication cycle in clocks, held stable |
| sync_offset | input | CNT_W | Delay from predicted arrival to sync pulse, in clocks |
| pred_arrive | output | 1 | Predicted-arrival pulse |
| frame_lost | output | 1 | One-clock flag for a missing frame |
| sync_out | output | 1 | Sync pulse |

## Verification
The hardest situations to reach from the ports are the ones where the loss detector and the corrected period interact. One example is a late frame that stretches the period, followed by a loss that pulls the period back to nominal in the middle of an interval. Another is the shortened post-loss limit that a later real frame must lengthen again. The stimulus places each `frame_ok` strobe at an exact edge relative to the origin frame, with offsets one clock outside the tolerance band and inside it. The bench then records the edge of every `pred_arrive`, `frame_lost` and `sync_out` pulse and compares those edges with a timeline worked out by hand.

// File: rtl/arrival_pkg.sv
// Package arrival_pkg
// Shared types and the phase classifier used by the arrival predictor.
// Assumes all counts fit in 32 bits.
package arrival_pkg;

    typedef enum logic [1:0] {
        PH_BAND  = 2'd0,
        PH_LATE  = 2'd1,
        PH_EARLY = 2'd2
    } phase_e;

    // Classify a frame that lands t clocks after the last predicted pulse
    // (t = per means it coincides with the next pulse).
    function automatic phase_e classify(input logic [31:0] t,
                                        input logic [31:0] per,
                                        input int unsigned th);
        if (t >= per)
            return PH_BAND;
        if (t <= (per >> 1))
            return (t > th) ? PH_LATE : PH_BAND;
        return ((per - t) > th) ? PH_EARLY : PH_BAND;
    endfunction

endpackage

// File: rtl/interval_tracker.sv
// Module interval_tracker
// Runs the prediction counter. The first frame sets the origin. Each real
// frame picks the period for the interval in progress (nominal, or nominal
// plus or minus one step), and a loss event returns the period to nominal.
// Assumes cycle_len is held stable, is at least 4, and DIFF_TH >= CORR_STEP.
module interval_tracker
    import arrival_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DIFF_TH   = 2,
    parameter int unsigned CORR_STEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_ok,
    input  logic             loss_hit,
    input  logic [CNT_W-1:0] cycle_len,
    output logic             running,
    output logic             pred_arrive
);
    localparam int unsigned CW1 = CNT_W + 1;

    logic [CNT_W-1:0] pred_cnt;
    logic [CNT_W-1:0] pred_int;
    logic [CW1-1:0]   t_cnt;
    logic             wrap;
    phase_e           ph;
    logic [CNT_W-1:0] nxt_int;

    // Position of the current clock within the predicted interval
    always_comb begin
        t_cnt = {1'b0, pred_cnt} + CW1'(1);
        wrap  = running && (t_cnt >= {1'b0, pred_int});
        ph    = classify(32'(t_cnt), 32'(pred_int), DIFF_TH);
    end

    // Period chosen from the measured phase of a real frame
    always_comb begin
        case (ph)
            PH_LATE:  nxt_int = cycle_len + CNT_W'(CORR_STEP);
            PH_EARLY: nxt_int = cycle_len - CNT_W'(CORR_STEP);
            default:  nxt_int = cycle_len;
        endcase
    end

    // Origin capture, counter wrap, period update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running     <= 1'b0;
            pred_cnt    <= '0;
            pred_int    <= '0;
            pred_arrive <= 1'b0;
        end else if (!running) begin
            pred_arrive <= 1'b0;
            if (frame_ok) begin
                running     <= 1'b1;
                pred_cnt    <= '0;
                pred_int    <= cycle_len;
                pred_arrive <= 1'b1;
            end
        end else begin
            if (wrap) begin
                pred_cnt    <= '0;
                pred_arrive <= 1'b1;
            end else begin
                pred_cnt    <= pred_cnt + CNT_W'(1);
                pred_arrive <= 1'b0;
            end
            if (frame_ok)
                pred_int <= nxt_int;
            else if (loss_hit)
                pred_int <= cycle_len;
        end
    end

    // R1: no predicted pulse before the origin frame
    a_r1_quiet_before_origin: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pred_arrive);

    // R2: predicted pulses are single clocks
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pred_arrive |=> !pred_arrive);

    // R4 / R5 / R6: the period never leaves nominal +/- one step
    a_r5_period_window: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ((32'(pred_int) <= 32'(cycle_len) + CORR_STEP) &&
                     (32'(pred_int) + CORR_STEP >= 32'(cycle_len))));

endmodule

// File: rtl/loss_watchdog.sv
// Module loss_watchdog
// Counts clocks since the last real or assumed frame. It raises loss_hit
// when the count reaches the limit: nominal + MAX_FLUCT normally, plain
// nominal right after a loss. frame_lost is the registered flag.
// Assumes cycle_len is held stable.
module loss_watchdog #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned MAX_FLUCT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             frame_ok,
    input  logic [CNT_W-1:0] cycle_len,
    output logic             loss_hit,
    output logic             frame_lost
);
    localparam int unsigned CW1 = CNT_W + 1;

    logic [CW1-1:0] gap_cnt;
    logic [CW1-1:0] limit;
    logic           after_loss;

    // Active gap limit and the loss condition
    always_comb begin
        limit    = after_loss ? {1'b0, cycle_len}
                              : {1'b0, cycle_len} + CW1'(MAX_FLUCT);
        loss_hit = running && !frame_ok && (gap_cnt >= limit);
    end

    // Gap counter, post-loss mode and the lost flag
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            gap_cnt    <= '0;
            after_loss <= 1'b0;
            frame_lost <= 1'b0;
        end else if (frame_ok) begin
            gap_cnt    <= '0;
            after_loss <= 1'b0;
            frame_lost <= 1'b0;
        end else if (loss_hit) begin
            gap_cnt    <= '0;
            after_loss <= 1'b1;
            frame_lost <= 1'b1;
        end else begin
            gap_cnt    <= gap_cnt + CW1'(1);
            frame_lost <= 1'b0;
        end
    end

    // R7: a loss is flagged for exactly one clock
    a_r7_lost_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_lost |=> !frame_lost);

    // R8: a real frame at the limit edge prevents the loss
    a_r8_frame_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && running) |=> !frame_lost);

endmodule

// File: rtl/sync_delay_timer.sv
// Module sync_delay_timer
// Loads the offset on each predicted-arrival pulse, counts it down, and
// then emits one sync pulse. A new arrival pulse reloads the delay.
module sync_delay_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arrive,
    input  logic [CNT_W-1:0] offset,
    output logic             sync_out
);
    logic [CNT_W-1:0] tmr;
    logic             armed;

    // Delay countdown and sync pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr      <= '0;
            armed    <= 1'b0;
            sync_out <= 1'b0;
        end else begin
            sync_out <= 1'b0;
            if (arrive) begin
                tmr   <= offset;
                armed <= 1'b1;
            end else if (armed) begin
                if (tmr == '0) begin
                    sync_out <= 1'b1;
                    armed    <= 1'b0;
                end else begin
                    tmr <= tmr - CNT_W'(1);
                end
            end
        end
    end

    // R9: a sync pulse only ends an armed countdown
    a_r9_fire_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> $past(armed));

endmodule

// File: rtl/frame_arrival_sync.sv
// Module frame_arrival_sync
// Top of the arrival predictor. It connects the interval tracker, the loss
// watchdog and the sync delay timer. Assumes frame_ok strobes last one
// clock and cycle_len stays constant while running.
module frame_arrival_sync #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DIFF_TH   = 2,
    parameter int unsigned CORR_STEP = 1,
    parameter int unsigned MAX_FLUCT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_ok,
    input  logic [CNT_W-1:0] cycle_len,
    input  logic [CNT_W-1:0] sync_offset,
    output logic             pred_arrive,
    output logic             frame_lost,
    output logic             sync_out
);
    logic running;
    logic loss_hit;

    interval_tracker #(
        .CNT_W     (CNT_W),
        .DIFF_TH   (DIFF_TH),
        .CORR_STEP (CORR_STEP)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ok    (frame_ok),
        .loss_hit    (loss_hit),
        .cycle_len   (cycle_len),
        .running     (running),
        .pred_arrive (pred_arrive)
    );

    loss_watchdog #(
        .CNT_W     (CNT_W),
        .MAX_FLUCT (MAX_FLUCT)
    ) u_loss (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .frame_ok   (frame_ok),
        .cycle_len  (cycle_len),
        .loss_hit   (loss_hit),
        .frame_lost (frame_lost)
    );

    sync_delay_timer #(
        .CNT_W (CNT_W)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive   (pred_arrive),
        .offset   (sync_offset),
        .sync_out (sync_out)
    );

    // R1: nothing is flagged lost before the origin frame
    a_r1_no_loss_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !frame_lost);

endmodule

// File: tb/frame_arrival_sync_test.sv
`timescale 1ns/1ps
module frame_arrival_sync_test;
    localparam int P = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_ok = 1'b0;
    logic [15:0] cycle_len = 16'(P);
    logic [15:0] sync_offset = 16'd5;
    logic        pred_arrive, frame_lost, sync_out;

    int cyc = 0;
    int nchk = 0, nfail = 0;
    int pred_log[64], sync_log[64], lost_log[64];
    int pn = 0, sn = 0, ln = 0;

    frame_arrival_sync uut (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
        .cycle_len(cycle_len), .sync_offset(sync_offset),
        .pred_arrive(pred_arrive), .frame_lost(frame_lost), .sync_out(sync_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Log the edge index of every output pulse
    always @(negedge clk) begin
        if (pred_arrive && pn < 64) begin pred_log[pn] = cyc; pn++; end
        if (sync_out && sn < 64)    begin sync_log[sn] = cyc; sn++; end
        if (frame_lost && ln < 64)  begin lost_log[ln] = cyc; ln++; end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int off);
        rst_n = 1'b0;
        sync_offset = 16'(off);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pn = 0; sn = 0; ln = 0;
        @(negedge clk);
    endtask

    task automatic send_frame(input int e);
        while (cyc < e - 1) @(negedge clk);
        frame_ok = 1'b1;
        @(negedge clk);
        frame_ok = 1'b0;
    endtask

    task automatic settle(input int e);
        while (cyc < e + 1) @(negedge clk);
    endtask

    // R1: quiet until the origin frame
    task automatic t_idle();
        do_reset(5);
        chk("R1 pred after reset", int'(pred_arrive), 0);
        chk("R1 sync after reset", int'(sync_out), 0);
        settle(cyc + 100);
        chk("R1 pred count idle", pn, 0);
        chk("R1 lost count idle", ln, 0);
        chk("R1 sync count idle", sn, 0);
    endtask

    // R2, R3, R9: origin and on-time frames
    task automatic t_on_time();
        int b;
        do_reset(5);
        b = cyc + 5;
        send_frame(b);
        send_frame(b + P);
        send_frame(b + 2 * P);
        settle(b + 125);
        chk("R2 origin pulse", pred_log[0] - b, 0);
        chk("R3 coincident pulse", pred_log[1] - b, 40);
        chk("R3 pulse after coincident", pred_log[2] - b, 80);
        chk("R2 nominal spacing", pred_log[3] - b, 120);
        chk("R2 pulse count", pn, 4);
        chk("R9 sync offset 5 first", sync_log[0] - b, 7);
        chk("R9 sync offset 5 second", sync_log[1] - b, 47);
        chk("R8 no loss with frames", ln, 0);
    endtask

    // R4, R7, R8: late frame, then losses
    task automatic t_late();
        int b;
        do_reset(5);
        b = cyc + 5;
        send_frame(b);
        send_frame(b + 44);
        settle(b + 180);
        chk("R4 late stretches period", pred_log[2] - b, 81);
        chk("R7 loss resets period", pred_log[3] - b, 121);
        chk("R7 first loss", lost_log[0] - b, 93);
        chk("R8 second loss at nominal", lost_log[1] - b, 134);
        chk("R8 third loss at nominal", lost_log[2] - b, 175);
    endtask

    // R5, R6: in-band late frame, then early frame
    task automatic t_early();
        int b;
        do_reset(5);
        b = cyc + 5;
        send_frame(b);
        send_frame(b + 42);
        send_frame(b + 77);
        settle(b + 160);
        chk("R6 band keeps nominal", pred_log[2] - b, 79);
        chk("R5 early shrinks period", pred_log[3] - b, 118);
        chk("R7 loss after early", lost_log[0] - b, 126);
        chk("R7 nominal after loss", pred_log[4] - b, 158);
    endtask

    // R7, R8: dead reckoning, then a real frame restores the limit
    task automatic t_dead_reckon();
        int b;
        do_reset(5);
        b = cyc + 5;
        send_frame(b);
        send_frame(b + 160);
        settle(b + 212);
        chk("R7 loss one", lost_log[0] - b, 49);
        chk("R8 loss two", lost_log[1] - b, 90);
        chk("R8 loss three", lost_log[2] - b, 131);
        chk("R8 limit restored", lost_log[3] - b, 209);
        chk("R7 pulses continue", pred_log[5] - b, 200);
    endtask

    // R9: zero offset
    task automatic t_zero_offset();
        int b;
        do_reset(0);
        b = cyc + 5;
        send_frame(b);
        settle(b + 45);
        chk("R9 zero offset first", sync_log[0] - b, 2);
        chk("R9 zero offset second", sync_log[1] - b, 42);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_idle();
        t_on_time();
        t_late();
        t_early();
        t_dead_reckon();
        t_zero_offset();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #1000000;
        nchk++;
        nfail++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule